// File: doc/BRIEF.md
# Clock Fault Switchover Controller

This block sits behind a clock failure detector and turns its verdict into system action. The verdict arrives from the slow reference clock domain, so it is first brought into the local clock domain. The block then keeps two sticky fault flags that are cleared in different ways, raises an interrupt, exports a fault line that a PWM block uses to drive its outputs to a safe state, and moves the main-clock and CPU-clock source selections away from a failed crystal.

Software configures two automatic switchover enables. The main-clock switch moves the main clock from the crystal to the internal RC oscillator. The CPU-clock switch moves the CPU clock from the PLL to the main clock. The CPU switch can only be armed once the main switch is already armed, so the CPU never ends up on a main clock that still runs from a dead crystal. Forced selections hold until software writes the clock selection again. The glitch-free muxes and the oscillators themselves are outside this block.

Top module: `clk_fail_switch`

## Requirements
- R1: After reset the event flag, fault flag, interrupt, fault output and live status are 0, the main select is 0 (crystal), the CPU select is 0 (PLL), and both automatic enables are disarmed.
- R2: When the detector is enabled and the verdict input rises, the event flag and the fault flag both become 1 exactly SYNC_STAGES+1 clock edges after the verdict was sampled. With the default SYNC_STAGES=2 that is 3 edges, within the 6-cycle switchover budget.
- R3: While the detector enable is 0, the verdict has no effect on the flags, the interrupt, the fault output or the selects.
- R4: A status read strobe clears the event flag on the next edge and leaves the fault flag unchanged.
- R5: The fault flag clears only when the fault clear strobe is 1. The fault output always equals the fault flag.
- R6: If a new failure event and a read strobe or fault clear strobe fall in the same cycle, both flags end up set.
- R7: The interrupt is 1 exactly when the event flag and the interrupt enable are both 1.
- R8: The live status equals the synchronized verdict ANDed with the detector enable. It follows the verdict input SYNC_STAGES edges later, whatever the flags hold.
- R9: On a failure event with automatic main switching armed, the main select becomes 1 (internal RC). With it disarmed, the main select keeps its value.
- R10: On a failure event with automatic CPU switching armed, the CPU select becomes 1 (main clock). A configuration write arms CPU switching only if it also sets main switching and main switching was already armed before that write.
- R11: Forced selections persist until a selection write. A failure event in the same cycle as a selection write takes priority for each armed select.
- R12: The RC power enable is 1 whenever the detector is enabled or the main select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_enable | input | 1 | Failure detector enable |
| fail_verdict | input | 1 | Failure verdict level from the detector (reference domain) |
| sts_rd | input | 1 | Status read strobe, clears the event flag |
| flt_clr | input | 1 | Fault clear strobe, clears the fault flag |
| irq_en | input | 1 | Interrupt enable for the event flag |
| cfg_wr | input | 1 | Write strobe for the automatic switch enables |
| cfg_auto_main | input | 1 | Automatic main-clock switch enable value |
| cfg_auto_cpu | input | 1 | Automatic CPU-clock switch enable value |
| sel_wr | input | 1 | Software clock selection write strobe |
| sw_main_rc | input | 1 | Main select value written by software (1 = RC) |
| sw_cpu_main | input | 1 | CPU select value written by software (1 = main clock) |
| evt_flag | output | 1 | Sticky event flag |
| flt_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Interrupt request |
| live_status | output | 1 | Current synchronized detector status |
| pwm_fault | output | 1 | Fault output to the PWM protection input |
| main_sel | output | 1 | Main-clock mux select (0 crystal, 1 RC) |
| cpu_sel | output | 1 | CPU-clock mux select (0 PLL, 1 main clock) |
| rc_pwr_en | output | 1 | Internal RC oscillator power enable |

## Verification
The bench sweeps every combination of the main and CPU automatic enables, their write order, the detector enable and the interrupt enable. For each one it computes the expected flags and selects arithmetically, so an arming rule that ignored the write order would show up as a CPU select that moved when it should have stayed. It samples one edge before the expected latency to catch a chain that is too short or too long. It fires a read strobe, a fault clear and a selection write in the exact cycle of a new event, and a design that let the clear or the software write win would drop the flag or undo the forced switch. It also checks that the fault flag survives status reads and that forced selects persist after the verdict falls.

// File: rtl/clk_fail_switch_pkg.sv
package clk_fail_switch_pkg;
   typedef enum logic {MAIN_XTAL = 1'b0, MAIN_RC = 1'b1} main_src_e;
   typedef enum logic {CPU_PLL = 1'b0, CPU_MAIN = 1'b1} cpu_src_e;
   localparam int unsigned SWITCH_BUDGET_DEF = 6;
endpackage

// File: rtl/clk_fail_switch_sync.sv
module clk_fail_switch_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d_in;
            else chain_q <= {chain_q[STAGES-2:0], d_in};
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/clk_fail_switch_flags.sv
module clk_fail_switch_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_rise,
   input  logic sts_rd,
   input  logic flt_clr,
   input  logic irq_en,
   output logic evt_flag,
   output logic flt_flag,
   output logic irq
);
   logic evt_q, flt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
         flt_q <= 1'b0;
      end else begin
         evt_q <= (evt_q & ~sts_rd) | fail_rise;
         flt_q <= (flt_q & ~flt_clr) | fail_rise;
      end
   end

   assign evt_flag = evt_q;
   assign flt_flag = flt_q;
   assign irq      = evt_q & irq_en;

   assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fail_rise |=> (evt_q && flt_q));
   assert_evt_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd && !fail_rise) |=> !evt_q);
   assert_flt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q && !flt_clr) |=> flt_q);
endmodule

// File: rtl/clk_fail_switch_srcsel.sv
module clk_fail_switch_srcsel
   import clk_fail_switch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fail_rise,
   input  logic cfg_wr,
   input  logic cfg_auto_main,
   input  logic cfg_auto_cpu,
   input  logic sel_wr,
   input  logic sw_main_rc,
   input  logic sw_cpu_main,
   output logic main_sel,
   output logic cpu_sel
);
   logic      auto_main_q, auto_cpu_q;
   main_src_e main_q;
   cpu_src_e  cpu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_main_q <= 1'b0;
         auto_cpu_q  <= 1'b0;
      end else if (cfg_wr) begin
         auto_main_q <= cfg_auto_main;
         auto_cpu_q  <= cfg_auto_cpu & cfg_auto_main & auto_main_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= MAIN_XTAL;
         cpu_q  <= CPU_PLL;
      end else begin
         if (fail_rise && auto_main_q) main_q <= MAIN_RC;
         else if (sel_wr)              main_q <= main_src_e'(sw_main_rc);
         if (fail_rise && auto_cpu_q)  cpu_q  <= CPU_MAIN;
         else if (sel_wr)              cpu_q  <= cpu_src_e'(sw_cpu_main);
      end
   end

   assign main_sel = main_q;
   assign cpu_sel  = cpu_q;

   assert_cpu_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      auto_cpu_q |-> auto_main_q);
   assert_main_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_rise && auto_main_q) |=> main_sel);
   assert_main_persist_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (main_sel && !sel_wr) |=> main_sel);
endmodule

// File: rtl/clk_fail_switch.sv
module clk_fail_switch
   import clk_fail_switch_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SWITCH_BUDGET = SWITCH_BUDGET_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_enable,
   input  logic fail_verdict,
   input  logic sts_rd,
   input  logic flt_clr,
   input  logic irq_en,
   input  logic cfg_wr,
   input  logic cfg_auto_main,
   input  logic cfg_auto_cpu,
   input  logic sel_wr,
   input  logic sw_main_rc,
   input  logic sw_cpu_main,
   output logic evt_flag,
   output logic flt_flag,
   output logic irq,
   output logic live_status,
   output logic pwm_fault,
   output logic main_sel,
   output logic cpu_sel,
   output logic rc_pwr_en
);
   localparam int unsigned LATENCY = SYNC_STAGES + 1;

   generate
      if (LATENCY > SWITCH_BUDGET) begin : g_budget_bad
         $error("switchover latency exceeds budget");
      end
   endgenerate

   logic verdict_s, live, live_q, fail_rise;

   clk_fail_switch_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_in(fail_verdict), .d_out(verdict_s));

   assign live = verdict_s & det_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= live;
   end

   assign fail_rise = live & ~live_q;

   clk_fail_switch_flags flags_i (
      .clk(clk), .rst_n(rst_n), .fail_rise(fail_rise), .sts_rd(sts_rd),
      .flt_clr(flt_clr), .irq_en(irq_en), .evt_flag(evt_flag),
      .flt_flag(flt_flag), .irq(irq));

   clk_fail_switch_srcsel srcsel_i (
      .clk(clk), .rst_n(rst_n), .fail_rise(fail_rise), .cfg_wr(cfg_wr),
      .cfg_auto_main(cfg_auto_main), .cfg_auto_cpu(cfg_auto_cpu),
      .sel_wr(sel_wr), .sw_main_rc(sw_main_rc), .sw_cpu_main(sw_cpu_main),
      .main_sel(main_sel), .cpu_sel(cpu_sel));

   assign live_status = live;
   assign pwm_fault   = flt_flag;
   assign rc_pwr_en   = det_enable | main_sel;

   assert_no_evt_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_enable && !evt_flag && !sts_rd) |=> !evt_flag);
   assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_flag && irq_en));
   assert_rc_pwr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      main_sel |-> rc_pwr_en);
endmodule

// File: tb/clk_fail_switch_tb.sv
module clk_fail_switch_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic det_enable = 0, fail_verdict = 0, sts_rd = 0, flt_clr = 0, irq_en = 0;
   logic cfg_wr = 0, cfg_auto_main = 0, cfg_auto_cpu = 0;
   logic sel_wr = 0, sw_main_rc = 0, sw_cpu_main = 0;
   logic evt_flag, flt_flag, irq, live_status, pwm_fault, main_sel, cpu_sel, rc_pwr_en;
   int   n_chk = 0, n_bad = 0;
   bit   done = 0;

   always #10 clk = ~clk;

   clk_fail_switch dut_i (.*);

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic nedge(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(logic m, logic c);
      cfg_auto_main = m; cfg_auto_cpu = c; cfg_wr = 1; nedge(1); cfg_wr = 0;
   endtask

   task automatic swsel(logic m, logic c);
      sw_main_rc = m; sw_cpu_main = c; sel_wr = 1; nedge(1); sel_wr = 0;
   endtask

   task automatic restore();
      fail_verdict = 0; det_enable = 0; irq_en = 0;
      nedge(3);
      swsel(0, 0); cfg(0, 0);
      sts_rd = 1; flt_clr = 1; nedge(1); sts_rd = 0; flt_clr = 0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      nedge(2);
      // R1 reset state
      chk("R1 evt", evt_flag, 0); chk("R1 flt", flt_flag, 0); chk("R1 irq", irq, 0);
      chk("R1 main", main_sel, 0); chk("R1 cpu", cpu_sel, 0); chk("R1 live", live_status, 0);
      rst_n = 1; nedge(1);

      // Sweep: am, ac, write order, detector enable, irq enable
      for (int v = 0; v < 32; v++) begin
         logic am, ac, sq, de, ie, arm_cpu;
         am = v[0]; ac = v[1]; sq = v[2]; de = v[3]; ie = v[4];
         arm_cpu = am & ac & sq;
         restore();
         if (sq) begin cfg(am, 0); cfg(am, ac); end
         else cfg(am, ac);
         det_enable = de; irq_en = ie; nedge(1);
         fail_verdict = 1;
         nedge(2);
         chk("R2 early evt", evt_flag, 0);
         chk("R8 live", live_status, de);
         nedge(1);
         chk("R2/R3 evt", evt_flag, de); chk("R2/R3 flt", flt_flag, de);
         chk("R7 irq", irq, de & ie); chk("R5 pwm", pwm_fault, de);
         chk("R9 main", main_sel, de & am); chk("R10 cpu", cpu_sel, de & arm_cpu);
         chk("R12 rcpwr", rc_pwr_en, de);
         sts_rd = 1; nedge(1); sts_rd = 0;
         chk("R4 evt clr", evt_flag, 0); chk("R4 flt kept", flt_flag, de);
         chk("R7 irq off", irq, 0);
         flt_clr = 1; nedge(1); flt_clr = 0;
         chk("R5 flt clr", flt_flag, 0); chk("R5 pwm clr", pwm_fault, 0);
         fail_verdict = 0; nedge(2);
         chk("R8 live drop", live_status, 0);
         nedge(3);
         chk("R11 main persist", main_sel, de & am);
         chk("R11 cpu persist", cpu_sel, de & arm_cpu);
         det_enable = 0; nedge(1);
         chk("R12 rcpwr sel", rc_pwr_en, de & am);
      end

      // R6: read and clear in the same cycle as a new event
      restore();
      det_enable = 1; fail_verdict = 1; nedge(2);
      sts_rd = 1; flt_clr = 1; nedge(1); sts_rd = 0; flt_clr = 0;
      chk("R6 evt", evt_flag, 1); chk("R6 flt", flt_flag, 1);

      // R11: failure beats same-cycle selection write; software write later wins
      restore();
      cfg(1, 0); cfg(1, 1);
      det_enable = 1; fail_verdict = 1; nedge(2);
      sw_main_rc = 0; sw_cpu_main = 0; sel_wr = 1; nedge(1); sel_wr = 0;
      chk("R11 main prio", main_sel, 1); chk("R11 cpu prio", cpu_sel, 1);
      nedge(4);
      swsel(0, 0);
      chk("R11 main rewrite", main_sel, 0); chk("R11 cpu rewrite", cpu_sel, 0);
      chk("R12 det en", rc_pwr_en, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule